// File: doc/BRIEF.md
# Serial-to-Nibble Receive Deframer

This block sits behind a receive framer that has already found frame alignment. It takes one bit per line-clock cycle, together with a frame-start strobe that marks bit 0 of a frame. It strips the overhead from the stream and hands the remaining payload to terminal equipment as 4-bit nibbles. The nibbles come with a gapped nibble clock and a receive framing flag.

Each frame holds `FRAME_BITS` bits. The first `HEAD_BITS` of them are overhead: the framing pattern followed by the service bits. When the parity enable is high, the final four bits of the frame carry the BIP-4 nibble and are treated as overhead too. Otherwise those four bits are payload. The nibble clock runs only while payload is arriving, so the terminal side sees no clock pulse for any overhead bit. The payload count per frame (`FRAME_BITS - HEAD_BITS`) must be a multiple of four.

Top module: `rx_nibble_deframer`

## Requirements
- R1: Within each nibble, `nib_data[3]` holds the earliest received payload bit and `nib_data[0]` holds the latest. The nibble is presented one clock after its fourth payload bit is sampled.
- R2: Bits at frame positions 0 to `HEAD_BITS-1` (framing pattern and service bits) never reach `nib_data`.
- R3: After a clock edge that samples an overhead bit, `nib_clk` is low for the following cycle.
- R4: Number the payload bits of a nibble 0 to 3. `nib_clk` is high in the cycle after bits 1 and 2 are sampled and low otherwise. This gives one pulse per nibble, two cycles high and two low when payload is continuous. `nib_data` changes only on the edge where `nib_clk` falls.
- R5: `nib_frame` goes high together with the last nibble of a frame. It stays high until the next nibble is loaded, and it is low with every other nibble.
- R6: With `bip_en` high, frame positions `FRAME_BITS-4` to `FRAME_BITS-1` are overhead: they are excluded from `nib_data`, they produce no clock pulse, and a frame yields one nibble fewer. With `bip_en` low, those positions are payload.
- R7: A bit sampled with `frame_start` high is frame position 0, whatever the counter held before.
- R8: A synchronous active-high `rst` drives `nib_data` to 0 and `nib_clk` and `nib_frame` low. The first bit sampled after reset is frame position 0.
- R9: Without `frame_start`, frame position `FRAME_BITS-1` is followed by position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line receive clock, one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bip_en | input | 1 | High: last four frame bits are the parity nibble (overhead) |
| frame_start | input | 1 | High with the bit at frame position 0 |
| bit_in | input | 1 | Aligned serial receive data |
| nib_data | output | 4 | Payload nibble, first received bit in bit 3 |
| nib_clk | output | 1 | Gapped nibble clock, data changes on its falling edge |
| nib_frame | output | 1 | High with the final nibble of a frame |

## Verification
Every cycle, the assertions check that the nibble clock stays low after overhead bits and that its pulses keep their two-high, two-low shape. They also check that data and the framing flag change only on a falling nibble clock, that the position counter stays in range, wraps and realigns on frame start, and that reset clears the outputs. The assertions cannot show that the right bits land in the right nibble lanes, that overhead content never leaks into the data, or that enabling parity removes exactly one nibble per frame. Those points rest on the bench's scenarios, which compare every cycle against a frame model. The scenarios cover both parity settings, several bit patterns, frames with and without frame-start strobes, a mid-frame realignment and a mid-frame reset.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int NIB_BITS = 4;

    typedef logic [NIB_BITS-1:0] nibble_t;

    // Classification of the bit presented in the current cycle
    typedef struct packed {
        logic       payload;   // bit belongs to the payload
        logic [1:0] phase;     // index of this payload bit within its nibble
        logic       last_nib;  // bit completes the final nibble of the frame
    } slot_t;

    // Fourth payload bit of a nibble: nibble is complete
    function automatic logic nibble_done(slot_t s);
        return s.payload && (s.phase == 2'd3);
    endfunction

    // Nibble clock is high after the second and third payload bits
    function automatic logic clk_high_next(slot_t s);
        return s.payload && ((s.phase == 2'd1) || (s.phase == 2'd2));
    endfunction

endpackage

// File: rtl/rxd_slot_locator.sv
module rxd_slot_locator
    import rxd_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int HEAD_BITS  = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_start,
    input  logic  bip_en,
    output slot_t slot
);

    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST_POS     = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] HEAD_POS     = CW'(HEAD_BITS);
    localparam logic [CW-1:0] PARITY_POS   = CW'(FRAME_BITS - NIB_BITS);
    localparam logic [CW-1:0] LAST_PAY_PAR = CW'(FRAME_BITS - NIB_BITS - 1);

    logic [CW-1:0] pos_q;
    logic [CW-1:0] pos_cur;
    logic [CW-1:0] pos_nxt;
    logic [CW-1:0] rel;

    always_comb begin
        pos_cur      = frame_start ? '0 : pos_q;
        pos_nxt      = (pos_cur == LAST_POS) ? '0 : pos_cur + CW'(1);
        rel          = pos_cur - HEAD_POS;
        slot.payload = (pos_cur >= HEAD_POS) && !(bip_en && (pos_cur >= PARITY_POS));
        slot.phase   = rel[1:0];
        slot.last_nib = slot.payload &&
                        (pos_cur == (bip_en ? LAST_PAY_PAR : LAST_POS));
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_nxt;
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);                                            // R9
    AST_REALIGN: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (pos_q == CW'(1)));                            // R7
    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pos_q == LAST_POS && !frame_start) |=> (pos_q == '0));        // R9

endmodule

// File: rtl/rxd_nibble_packer.sv
module rxd_nibble_packer
    import rxd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_in,
    input  slot_t   slot,
    output nibble_t nib_data,
    output logic    nib_frame
);

    logic [NIB_BITS-2:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            nib_data  <= '0;
            nib_frame <= 1'b0;
        end else if (slot.payload) begin
            sr <= {sr[NIB_BITS-3:0], bit_in};
            if (nibble_done(slot)) begin
                nib_data  <= {sr, bit_in};
                nib_frame <= slot.last_nib;
            end
        end
    end

    AST_FRAME_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(nib_frame) |-> $past(slot.payload));                     // R5

endmodule

// File: rtl/rxd_nibclk_gen.sv
module rxd_nibclk_gen
    import rxd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t slot,
    output logic  nib_clk
);

    always_ff @(posedge clk) begin
        if (rst) nib_clk <= 1'b0;
        else     nib_clk <= clk_high_next(slot);
    end

endmodule

// File: rtl/rx_nibble_deframer.sv
module rx_nibble_deframer
    import rxd_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int HEAD_BITS  = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bip_en,
    input  logic       frame_start,
    input  logic       bit_in,
    output logic [3:0] nib_data,
    output logic       nib_clk,
    output logic       nib_frame
);

    slot_t   slot;
    nibble_t data_w;

    rxd_slot_locator #(
        .FRAME_BITS (FRAME_BITS),
        .HEAD_BITS  (HEAD_BITS)
    ) u_locator (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .bip_en      (bip_en),
        .slot        (slot)
    );

    rxd_nibble_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .slot      (slot),
        .nib_data  (data_w),
        .nib_frame (nib_frame)
    );

    rxd_nibclk_gen u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .slot    (slot),
        .nib_clk (nib_clk)
    );

    assign nib_data = data_w;

    AST_GAP_OVERHEAD: assert property (@(posedge clk) disable iff (rst)
        !slot.payload |=> !nib_clk);                                   // R3
    AST_PULSE_HIGH_TWO: assert property (@(posedge clk) disable iff (rst)
        ($rose(nib_clk) && !frame_start) |=> nib_clk);                 // R4
    AST_PULSE_LOW_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(nib_clk) |=> !nib_clk);                                  // R4
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (nib_data != $past(nib_data)) |-> $fell(nib_clk));             // R4
    AST_FRAME_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(nib_frame) |-> $fell(nib_clk));                          // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (nib_data == 4'd0 && !nib_clk && !nib_frame));         // R8

endmodule

// File: tb/test_rx_nibble_deframer.sv
`timescale 1ns/1ps
module test_rx_nibble_deframer;

    localparam int F = 1536;
    localparam int H = 12;

    typedef struct packed {
        logic       bip;
        logic [7:0] seed;
        logic       fs_each;
        logic [1:0] frames;
    } scn_t;

    // bip, seed, frame_start on every frame, frame count
    localparam scn_t SCN [4] = '{
        '{1'b0, 8'hA5, 1'b1, 2'd2},
        '{1'b1, 8'h3C, 1'b1, 2'd2},
        '{1'b0, 8'h01, 1'b0, 2'd2},
        '{1'b1, 8'hFF, 1'b0, 2'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bip_en = 1'b0;
    logic       frame_start = 1'b0;
    logic       bit_in = 1'b0;
    logic [3:0] nib_data;
    logic       nib_clk;
    logic       nib_frame;

    always #2 clk = ~clk;

    rx_nibble_deframer #(.FRAME_BITS(F), .HEAD_BITS(H)) i_rx_nibble_deframer (
        .clk         (clk),
        .rst         (rst),
        .bip_en      (bip_en),
        .frame_start (frame_start),
        .bit_in      (bit_in),
        .nib_data    (nib_data),
        .nib_clk     (nib_clk),
        .nib_frame   (nib_frame)
    );

    int         n_checks = 0;
    int         n_bad = 0;
    int         p = 0;
    int         pulses = 0;
    logic       prev_clk = 1'b0;
    logic [3:0] e_sr = 4'd0;
    logic [3:0] e_data = 4'd0;
    logic       e_clk = 1'b0;
    logic       e_frame = 1'b0;
    logic [7:0] lf = 8'h01;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lf_next(logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    // Drive one bit, update the frame model, check all outputs
    task automatic step(input logic b, input logic fs, input string scen);
        logic  pay;
        int    ph;
        string dtag;
        bit_in      = b;
        frame_start = fs;
        @(posedge clk);
        if (fs) p = 0;
        pay  = (p >= H) && !(bip_en && p >= F - 4);
        ph   = (p - H) & 3;
        dtag = (bip_en && p >= F - 4) ? "R6" : ((p < H) ? "R2" : "R1");
        e_clk = pay && (ph == 1 || ph == 2);
        if (pay) begin
            e_sr = {e_sr[2:0], b};
            if (ph == 3) begin
                e_data  = e_sr;
                e_frame = (p == (bip_en ? F - 5 : F - 1));
            end
        end
        @(negedge clk);
        check(nib_data == e_data, $sformatf("%s data %s pos=%0d", dtag, scen, p),
              nib_data, e_data);
        check(nib_clk == e_clk, $sformatf("%s clk %s pos=%0d", pay ? "R4" : "R3", scen, p),
              nib_clk, e_clk);
        check(nib_frame == e_frame, $sformatf("R5 frame %s pos=%0d", scen, p),
              nib_frame, e_frame);
        if (nib_clk && !prev_clk) pulses++;
        prev_clk = nib_clk;
        p = (p == F - 1) ? 0 : p + 1;
    endtask

    task automatic do_reset(input string scen);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(nib_data == 4'd0, {"R8 data ", scen}, nib_data, 0);
        check(nib_clk == 1'b0, {"R8 clk ", scen}, nib_clk, 0);
        check(nib_frame == 1'b0, {"R8 frame ", scen}, nib_frame, 0);
        p = 0; e_sr = 0; e_data = 0; e_clk = 0; e_frame = 0; prev_clk = 0;
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("initial");

        // Vector table: parity mode, bit pattern, strobe usage
        for (int i = 0; i < 4; i++) begin
            string scen;
            scen   = SCN[i].fs_each ? $sformatf("scn%0d", i) : $sformatf("scn%0d R9 wrap", i);
            bip_en = SCN[i].bip;
            lf     = SCN[i].seed;
            for (int f = 0; f < int'(SCN[i].frames); f++) begin
                pulses = 0;
                for (int k = 0; k < F; k++) begin
                    lf = lf_next(lf);
                    step(lf[0], (k == 0) && (f == 0 || SCN[i].fs_each), scen);
                end
                check(pulses == (SCN[i].bip ? (F - H - 4) / 4 : (F - H) / 4),
                      $sformatf("%s pulse count %s", SCN[i].bip ? "R6" : "R4", scen),
                      pulses, SCN[i].bip ? (F - H - 4) / 4 : (F - H) / 4);
            end
        end

        // R2: overhead all ones, payload all zeros
        bip_en = 1'b1;
        for (int k = 0; k < F; k++) step(k < H || k >= F - 4, k == 0, "R2 marker");
        bip_en = 1'b0;
        for (int k = 0; k < F; k++) step(k < H, k == 0, "R2 marker nobip");

        // R7: realign in mid-frame
        lf = 8'h5A;
        for (int k = 0; k < 701; k++) begin
            lf = lf_next(lf);
            step(lf[0], k == 0, "R7 pre");
        end
        for (int k = 0; k < F + 8; k++) begin
            lf = lf_next(lf);
            step(lf[0], k == 0, "R7 realign");
        end

        // R8: reset in mid-frame, then run without any frame strobe
        for (int k = 0; k < 303; k++) begin
            lf = lf_next(lf);
            step(lf[0], k == 0, "R8 pre");
        end
        @(negedge clk);
        do_reset("midframe");
        for (int k = 0; k < F + 8; k++) begin
            lf = lf_next(lf);
            step(lf[0], 1'b0, "R8 after reset");
        end

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule